// File: doc/BRIEF.md
# Polled Byte Port Controller

This block is a small register-mapped port through which a host moves one byte at a time to or from an attached device, using polling only. The host sees four word-addressed registers: a status word, a command word, a byte coming from the device (inbound), and a byte going to the device (outbound). A transfer is coordinated by two flags. The host owns the command-ready flag and the controller owns the busy flag.

To run a transfer, the host polls status until busy is clear. It then loads the outbound byte and the command word, and only after that sets command-ready. The controller marks itself busy and decodes the command. A write command offers the outbound byte to the device. A read command accepts a byte from the device into the inbound register. On completion the controller drops command-ready, reports success or failure in the error flag, and releases busy. Both device-side channels use a valid/ready byte handshake, and the controller stays busy for as long as the device stalls.

Top module: `polled_port_ctrl`

## Requirements
- R1: After reset, status reads 0, the inbound byte reads 0, and neither `dv_tx_valid` nor `dv_rx_ready` is asserted.
- R2: Offsets are 0 status, 1 command, 2 inbound byte (read-only), 3 outbound byte. Status bits are bit0 busy, bit1 command-ready, bit2 error, bit3 overrun, and the upper bits read 0. Writing status with bit1 = 1 sets command-ready only when busy and command-ready are both clear. Busy rises exactly one cycle after command-ready rises.
- R3: A command with bit0 (write) set alone offers the outbound byte on `dv_tx_data` with `dv_tx_valid` held, and the byte held stable, until `dv_tx_ready`. Each such command produces exactly one device transfer.
- R4: A command with bit1 (read) set alone asserts `dv_rx_ready` until `dv_rx_valid`. The byte accepted is then readable at offset 2.
- R5: Busy stays set for as long as the device handshake has not completed, however long the device stalls.
- R6: When a valid command completes, command-ready and busy clear at the same edge and error reads 0.
- R7: A command with both or neither of bits 0 and 1 set makes no device transfer. It sets error and then clears command-ready and busy.
- R8: While busy or command-ready is set, host writes to the command or outbound registers are ignored: both read back unchanged and the byte sent is the one loaded earlier. Each such write sets the overrun flag.
- R9: Overrun is sticky. Writing status with bit3 = 1 clears it, and writing status with bit3 = 0 leaves it unchanged.
- R10: A valid command that completes after a failed one clears error.
- R11: `dv_tx_valid` and `dv_rx_ready` are never asserted together, and neither is asserted while busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe for one cycle |
| hst_addr | input | 2 | Register word offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Register read data, combinational on `hst_addr` |
| dv_tx_valid | output | 1 | Outbound byte offered to the device |
| dv_tx_ready | input | 1 | Device accepts the outbound byte |
| dv_tx_data | output | 8 | Outbound byte |
| dv_rx_valid | input | 1 | Device offers an inbound byte |
| dv_rx_ready | output | 1 | Controller is waiting for an inbound byte |
| dv_rx_data | input | 8 | Inbound byte |

## Verification
The assertions take the device's side of the handshake as well-behaved but otherwise unconstrained. `dv_tx_ready` and `dv_rx_valid` may stall for any number of cycles, and `dv_rx_data` is only meaningful when valid is high. They also take the host to issue at most one register write per cycle. The bench drives host writes as single-cycle strobes set up between edges. Its device model raises ready or valid only after a programmed stall while the controller is requesting, and drops them once the request ends. Deliberate overrun writes are made only while a slow transfer keeps the port locked.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int OFS_STS  = 0;
  localparam int OFS_CMD  = 1;
  localparam int OFS_DIN  = 2;
  localparam int OFS_DOUT = 3;

  localparam int STS_BUSY = 0;
  localparam int STS_CRDY = 1;
  localparam int STS_ERR  = 2;
  localparam int STS_OVR  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_SEND, ST_RECV, ST_FIN
  } ppc_state_e;

  typedef enum logic [1:0] {K_BAD, K_WRITE, K_READ} ppc_kind_e;

  // bit0 = write, bit1 = read; exactly one must be set
  function automatic ppc_kind_e cmd_kind(input logic [1:0] bits);
    case (bits)
      2'b01:   return K_WRITE;
      2'b10:   return K_READ;
      default: return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/ppc_regs.sv
module ppc_regs
  import ppc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  input  logic              busy,
  input  logic              fin_ok,
  input  logic              fin_err,
  input  logic              din_load,
  input  logic [DATA_W-1:0] din_val,
  output logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] dout_q
);
  logic              err_q, ovr_q;
  logic [DATA_W-1:0] din_q;
  logic              wr_sts, wr_cmd, wr_dout, locked;
  logic [DATA_W-1:0] sts_word;

  assign wr_sts  = hst_wr && (hst_addr == ADDR_W'(OFS_STS));
  assign wr_cmd  = hst_wr && (hst_addr == ADDR_W'(OFS_CMD));
  assign wr_dout = hst_wr && (hst_addr == ADDR_W'(OFS_DOUT));
  assign locked  = busy || cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0;
      err_q     <= 1'b0;
      ovr_q     <= 1'b0;
      cmd_q     <= '0;
      dout_q    <= '0;
      din_q     <= '0;
    end else begin
      if (fin_ok || fin_err)
        cmd_ready <= 1'b0;
      else if (wr_sts && hst_wdata[STS_CRDY] && !locked)
        cmd_ready <= 1'b1;

      if (fin_err)     err_q <= 1'b1;
      else if (fin_ok) err_q <= 1'b0;

      if ((wr_cmd || wr_dout) && locked)
        ovr_q <= 1'b1;
      else if (wr_sts && hst_wdata[STS_OVR])
        ovr_q <= 1'b0;

      if (wr_cmd && !locked)  cmd_q  <= hst_wdata;
      if (wr_dout && !locked) dout_q <= hst_wdata;
      if (din_load)           din_q  <= din_val;
    end
  end

  always_comb begin
    sts_word           = '0;
    sts_word[STS_BUSY] = busy;
    sts_word[STS_CRDY] = cmd_ready;
    sts_word[STS_ERR]  = err_q;
    sts_word[STS_OVR]  = ovr_q;
    case (hst_addr)
      ADDR_W'(OFS_STS):  hst_rdata = sts_word;
      ADDR_W'(OFS_CMD):  hst_rdata = cmd_q;
      ADDR_W'(OFS_DIN):  hst_rdata = din_q;
      default:           hst_rdata = dout_q;
    endcase
  end

  // R8: locked registers keep their value and flag the overrun
  p_locked_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_cmd) |=> ($stable(cmd_q) && ovr_q));
  p_locked_dout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_dout) |=> ($stable(dout_q) && ovr_q));
  // R6: successful completion drops command-ready and error
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ok |=> (!cmd_ready && !err_q));
  // R7: failed completion raises error and drops command-ready
  p_bad_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> (err_q && !cmd_ready));
endmodule

// File: rtl/ppc_fsm.sv
module ppc_fsm
  import ppc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_ready,
  input  logic [1:0] cmd_bits,
  input  logic       tx_done,
  input  logic       rx_done,
  output logic       busy,
  output logic       send_en,
  output logic       recv_en,
  output logic       fin_ok,
  output logic       fin_err
);
  ppc_state_e state_q;
  logic       bad_q;
  ppc_kind_e  kind;

  assign kind = cmd_kind(cmd_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bad_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:   if (cmd_ready) state_q <= ST_DECODE;
        ST_DECODE: begin
          bad_q <= (kind == K_BAD);
          case (kind)
            K_WRITE: state_q <= ST_SEND;
            K_READ:  state_q <= ST_RECV;
            default: state_q <= ST_FIN;
          endcase
        end
        ST_SEND:   if (tx_done) state_q <= ST_FIN;
        ST_RECV:   if (rx_done) state_q <= ST_FIN;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign send_en = (state_q == ST_SEND);
  assign recv_en = (state_q == ST_RECV);
  assign fin_ok  = (state_q == ST_FIN) && !bad_q;
  assign fin_err = (state_q == ST_FIN) && bad_q;

  // R2: busy follows a raised command-ready by one cycle
  p_busy_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_ready) |=> busy);
  // R5: a pending device handshake holds busy
  p_stall_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((send_en && !tx_done) || (recv_en && !rx_done)) |=> busy);
endmodule

// File: rtl/ppc_devif.sv
module ppc_devif #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_en,
  input  logic              recv_en,
  input  logic [DATA_W-1:0] dout,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] din_val
);
  assign tx_valid = send_en;
  assign tx_data  = dout;
  assign rx_ready = recv_en;
  assign tx_done  = tx_valid && tx_ready;
  assign rx_done  = rx_valid && rx_ready;
  assign din_val  = rx_data;

  // R3: an offered byte stays offered and unchanged until taken
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R4: a read request stays up until the device answers
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_valid) |=> rx_ready);
endmodule

// File: rtl/polled_port_ctrl.sv
module polled_port_ctrl
  import ppc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              dv_tx_valid,
  input  logic              dv_tx_ready,
  output logic [DATA_W-1:0] dv_tx_data,
  input  logic              dv_rx_valid,
  output logic              dv_rx_ready,
  input  logic [DATA_W-1:0] dv_rx_data
);
  logic              busy, cmd_ready, fin_ok, fin_err;
  logic              send_en, recv_en, tx_done, rx_done;
  logic [DATA_W-1:0] cmd_q, dout_q, din_val;

  ppc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata),
    .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err),
    .din_load(rx_done), .din_val(din_val),
    .cmd_ready(cmd_ready), .cmd_q(cmd_q), .dout_q(dout_q)
  );

  ppc_fsm fsm_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_ready(cmd_ready), .cmd_bits(cmd_q[1:0]),
    .tx_done(tx_done), .rx_done(rx_done),
    .busy(busy), .send_en(send_en), .recv_en(recv_en),
    .fin_ok(fin_ok), .fin_err(fin_err)
  );

  ppc_devif #(.DATA_W(DATA_W)) devif_i (
    .clk(clk), .rst_n(rst_n),
    .send_en(send_en), .recv_en(recv_en), .dout(dout_q),
    .tx_valid(dv_tx_valid), .tx_ready(dv_tx_ready), .tx_data(dv_tx_data),
    .rx_valid(dv_rx_valid), .rx_ready(dv_rx_ready), .rx_data(dv_rx_data),
    .tx_done(tx_done), .rx_done(rx_done), .din_val(din_val)
  );

  // R11: channels exclusive and only active while busy
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dv_tx_valid && dv_rx_ready));
  p_active_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_tx_valid || dv_rx_ready) |-> busy);
  // R6: busy falls only together with command-ready clear
  p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !cmd_ready);
endmodule

// File: tb/polled_port_ctrl_tb_top.sv
module polled_port_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_wr = 1'b0;
  logic [1:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;
  logic       dv_tx_valid, dv_rx_ready;
  logic [7:0] dv_tx_data;
  logic       dv_tx_ready = 1'b0;
  logic       dv_rx_valid = 1'b0;
  logic [7:0] dv_rx_data = '0;

  int vectors = 0, miscompares = 0;
  int tx_stall = 0, rx_stall = 0, tx_wait = 0, rx_wait = 0;
  int tx_hs = 0, rx_hs = 0, excl_bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  polled_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata),
    .dv_tx_valid(dv_tx_valid), .dv_tx_ready(dv_tx_ready), .dv_tx_data(dv_tx_data),
    .dv_rx_valid(dv_rx_valid), .dv_rx_ready(dv_rx_ready), .dv_rx_data(dv_rx_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic read_now(input logic [1:0] a, output logic [7:0] d);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    read_now(a, d);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    bit done = 0;
    for (int i = 0; i < 500 && !done; i++) begin
      host_read(2'd0, s);
      if (s[1:0] == 2'b00) done = 1;
    end
  endtask

  // driver: load registers, queue expected byte, raise command-ready
  task automatic issue(input logic [7:0] cmd, input logic [7:0] dout);
    host_write(2'd3, dout);
    host_write(2'd1, cmd);
    if (cmd[1:0] == 2'b01) exp_q.push_back(dout);
    host_write(2'd0, 8'h02);
  endtask

  // device model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      dv_tx_ready = 1'b0; dv_rx_valid = 1'b0; tx_wait = 0; rx_wait = 0;
    end else begin
      if (dv_tx_valid) begin
        if (tx_wait >= tx_stall) dv_tx_ready = 1'b1;
        else begin dv_tx_ready = 1'b0; tx_wait++; end
      end else begin
        dv_tx_ready = 1'b0; tx_wait = 0;
      end
      if (dv_rx_ready) begin
        if (rx_wait >= rx_stall) dv_rx_valid = 1'b1;
        else begin dv_rx_valid = 1'b0; rx_wait++; end
      end else begin
        dv_rx_valid = 1'b0; rx_wait = 0;
      end
      #1;
      if (dv_tx_valid && dv_rx_ready) excl_bad++;
      if (dv_tx_valid && dv_tx_ready) begin
        tx_hs++;
        if (exp_q.size() == 0) check("R3 unexpected tx byte", dv_tx_data, 8'hxx);
        else check("R3 tx byte", dv_tx_data, exp_q.pop_front());
      end
      if (dv_rx_valid && dv_rx_ready) rx_hs++;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL R5 watchdog actual=hung expected=idle");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int h0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    host_read(2'd0, s); check("R1 status", s, 8'h00);
    host_read(2'd2, s); check("R1 inbound", s, 8'h00);
    check("R1 tx_valid", {7'd0, dv_tx_valid}, 8'h00);
    check("R1 rx_ready", {7'd0, dv_rx_ready}, 8'h00);

    // R2, R3, R6: write with short stall, cycle-exact busy rise
    tx_stall = 2;
    issue(8'h01, 8'hA5);
    read_now(2'd0, s);  check("R2 crdy before busy", s, 8'h02);
    host_read(2'd0, s); check("R2 busy one cycle later", s, 8'h03);
    wait_idle();
    host_read(2'd0, s); check("R6 status after write", s, 8'h00);

    // R5: long stall keeps busy
    tx_stall = 20;
    issue(8'h01, 8'h3E);
    repeat (12) @(negedge clk);
    read_now(2'd0, s); check("R5 busy during stall", s, 8'h03);
    wait_idle();
    host_read(2'd0, s); check("R5 status after stall", s, 8'h00);

    // R4: reads with and without stall
    rx_stall = 3; dv_rx_data = 8'h3C;
    issue(8'h02, 8'h00);
    wait_idle();
    host_read(2'd2, s); check("R4 inbound stalled", s, 8'h3C);
    rx_stall = 0; dv_rx_data = 8'hC3;
    issue(8'h02, 8'h00);
    wait_idle();
    host_read(2'd2, s); check("R4 inbound fast", s, 8'hC3);

    // R7: both and neither bits
    h0 = tx_hs; r0 = rx_hs;
    issue(8'h03, 8'h77);
    wait_idle();
    host_read(2'd0, s); check("R7 both bits error", s, 8'h04);
    issue(8'h00, 8'h77);
    wait_idle();
    host_read(2'd0, s); check("R7 no bits error", s, 8'h04);
    check("R7 no tx", 8'(tx_hs - h0), 8'h00);
    check("R7 no rx", 8'(rx_hs - r0), 8'h00);

    // R10: valid write clears error
    tx_stall = 0;
    issue(8'h01, 8'h11);
    wait_idle();
    host_read(2'd0, s); check("R10 error cleared", s, 8'h00);

    // R8: locked writes ignored and flagged
    tx_stall = 15;
    issue(8'h01, 8'h5A);
    host_write(2'd1, 8'h02);
    host_write(2'd3, 8'hFF);
    read_now(2'd0, s); check("R8 overrun while busy", s, 8'h0B);
    read_now(2'd1, s); check("R8 command unchanged", s, 8'h01);
    read_now(2'd3, s); check("R8 outbound unchanged", s, 8'h5A);
    wait_idle();
    host_read(2'd0, s); check("R8 overrun stays after done", s, 8'h08);

    // R9: clear semantics
    host_write(2'd0, 8'h00);
    read_now(2'd0, s); check("R9 write 0 keeps overrun", s, 8'h08);
    host_write(2'd0, 8'h08);
    read_now(2'd0, s); check("R9 write 1 clears overrun", s, 8'h00);

    // R3 completeness and R11
    repeat (3) @(negedge clk);
    check("R3 queue drained", 8'(exp_q.size()), 8'h00);
    check("R11 exclusive", 8'(excl_bad), 8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule